// File: doc/BRIEF.md
# Host DMA to Multi-Stream Bridge

This block sits between a host DMA port and a set of 32-bit hardware streams. The host side delivers one word per clock while its write strobe is high, and offers no way to pause. A 4-bit channel number picks the stream that the word is for. The bridge places each accepted word in an inbound FIFO, tagged with its channel. It then hands the words to the matching input stream whenever that stream's ready is high. A stream's ready may stay high, stay low, or flip every cycle, and no word is lost as long as a burst fits in the FIFO.

For the return path the host raises its read strobe and names a channel. The selected output stream then fills an outbound FIFO. That FIFO drains into the core's outgoing buffer, but never while the core reports that buffer full. A control write on a channel asks for the stream to be closed. The request moves through the inbound FIFO behind the data written before it. The stream's end-of-stream flag rises only once that request reaches the head, so all earlier data has already drained.

Top module: `dma_stream_bridge`

## Requirements
- R1: A host write whose channel value c is below N_IN (default 2) is delivered only on input stream c. A write with c at or above N_IN is discarded. At most one input stream has its enable high in any cycle.
- R2: Words for one input stream come out in the order they were written, with none dropped or duplicated, even when a write arrives on every cycle.
- R3: A word leaves the inbound FIFO only on a cycle where the target stream's ready is high. While ready is low, that stream's enable and data hold unchanged.
- R4: Once the inbound FIFO holds IN_DEPTH (default 16) entries, further host writes are refused, and the stored entries drain unchanged and in order.
- R5: A host write with the control flag set (data ignored) on channel c sets in_eos_o bit c. This happens only after every entry written before the request has left the inbound FIFO. The request's data never appears on a stream, and the flag stays set until reset.
- R6: out_rdy_o bit k is high only when dma_ren_i is high, dma_chan_i equals k, and the outbound FIFO is not full. Only that stream's words are captured.
- R7: core_wen_o is never high while core_full_i is high. Outbound words reach core_wdata_o in capture order.
- R8: While rst_ni is low, both FIFOs are emptied and all end-of-stream flags are cleared. After reset, in_en_o, in_eos_o and core_wen_o are all zero.
- R9: Once the outbound FIFO holds OUT_DEPTH (default 16) words, out_rdy_o is low for every stream until the core accepts a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_wen_i | input | 1 | Host write strobe, one word per cycle |
| dma_ctrl_i | input | 1 | With dma_wen_i: close request for the channel instead of data |
| dma_chan_i | input | 4 | Channel number for host reads and writes |
| dma_wdata_i | input | 32 | Host write data |
| dma_ren_i | input | 1 | Host read strobe; enables capture from the selected output stream |
| core_full_i | input | 1 | Core outgoing buffer full |
| core_wen_o | output | 1 | Write strobe into the core outgoing buffer |
| core_wdata_o | output | 32 | Data into the core outgoing buffer |
| in_data_o | output | N_IN*32 | Input stream data, stream k in bits [32k+31:32k] |
| in_en_o | output | N_IN | Input stream word valid |
| in_rdy_i | input | N_IN | Input stream ready |
| in_eos_o | output | N_IN | Input stream end-of-stream |
| out_data_i | input | N_OUT*32 | Output stream data, stream k in bits [32k+31:32k] |
| out_en_i | input | N_OUT | Output stream word valid |
| out_rdy_o | output | N_OUT | Output stream ready |

## Verification
The hardest state to reach is an inbound FIFO already at capacity while the host is still writing. A close request queued behind stalled data is just as hard to reach. From the ports, both need the stream's ready held low for exactly the span of a burst. The bench gets there through a per-stream ready mode that it can set to low, high or alternating. It holds ready low while a burst longer than the FIFO depth, or a burst followed by a control write, is issued. It then releases ready and compares the delivered words and the moment the flag rises against what was written. The outbound side is taken to full in the same way, by holding the core-full input high while a producer keeps offering words.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CHAN_W = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CHAN_W-1:0] chan_t;

  // inbound FIFO entry: close request or data word, tagged with channel
  typedef struct packed {
    logic  eos;
    chan_t chan;
    word_t data;
  } in_ent_t;
endpackage

// File: rtl/dsb_fifo.sv
module dsb_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]   mem_q [DEPTH];
  logic [PTR_W:0] wptr_q, rptr_q;
  logic           do_push, do_pop;

  assign empty_o = (wptr_q == rptr_q);
  assign full_o  = (wptr_q[PTR_W] != rptr_q[PTR_W]) &&
                   (wptr_q[PTR_W-1:0] == rptr_q[PTR_W-1:0]);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rptr_q[PTR_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q[PTR_W-1:0]] <= wdata_i;
  end
endmodule

// File: rtl/dsb_in_steer.sv
module dsb_in_steer
  import dsb_pkg::*;
#(
  parameter int unsigned N_IN = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  in_ent_t                head_i,
  input  logic                   head_vld_i,
  input  logic [N_IN-1:0]        in_rdy_i,
  output logic                   pop_o,
  output logic [N_IN*WORD_W-1:0] in_data_o,
  output logic [N_IN-1:0]        in_en_o,
  output logic [N_IN-1:0]        in_eos_o
);
  logic [N_IN-1:0] hit;
  logic            sel_rdy;
  logic [N_IN-1:0] eos_q;

  always_comb begin
    sel_rdy = 1'b0;
    for (int k = 0; k < N_IN; k++) begin
      hit[k]     = (head_i.chan == chan_t'(k));
      in_en_o[k] = head_vld_i && !head_i.eos && hit[k];
      if (hit[k]) sel_rdy = in_rdy_i[k];
    end
  end

  // close entries retire at once; data waits for its stream
  assign pop_o = head_vld_i && (head_i.eos || sel_rdy);

  for (genvar g = 0; g < N_IN; g++) begin : g_data
    assign in_data_o[g*WORD_W +: WORD_W] = head_i.data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        eos_q <= '0;
    else if (head_vld_i && head_i.eos)  eos_q <= eos_q | hit;
  end

  assign in_eos_o = eos_q;
endmodule

// File: rtl/dsb_out_sel.sv
module dsb_out_sel
  import dsb_pkg::*;
#(
  parameter int unsigned N_OUT = 2
) (
  input  chan_t                   dma_chan_i,
  input  logic                    dma_ren_i,
  input  logic                    fifo_full_i,
  input  logic [N_OUT*WORD_W-1:0] out_data_i,
  input  logic [N_OUT-1:0]        out_en_i,
  output logic [N_OUT-1:0]        out_rdy_o,
  output logic                    push_o,
  output word_t                   push_data_o
);
  always_comb begin
    push_o      = 1'b0;
    push_data_o = '0;
    for (int k = 0; k < N_OUT; k++) begin
      out_rdy_o[k] = dma_ren_i && !fifo_full_i && (dma_chan_i == chan_t'(k));
      if (out_rdy_o[k]) begin
        push_o      = out_en_i[k];
        push_data_o = out_data_i[k*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/dma_stream_bridge.sv
module dma_stream_bridge
  import dsb_pkg::*;
#(
  parameter int unsigned N_IN      = 2,
  parameter int unsigned N_OUT     = 2,
  parameter int unsigned IN_DEPTH  = 16,
  parameter int unsigned OUT_DEPTH = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dma_wen_i,
  input  logic                    dma_ctrl_i,
  input  logic [3:0]              dma_chan_i,
  input  logic [31:0]             dma_wdata_i,
  input  logic                    dma_ren_i,
  input  logic                    core_full_i,
  output logic                    core_wen_o,
  output logic [31:0]             core_wdata_o,
  output logic [N_IN*32-1:0]      in_data_o,
  output logic [N_IN-1:0]         in_en_o,
  input  logic [N_IN-1:0]         in_rdy_i,
  output logic [N_IN-1:0]         in_eos_o,
  input  logic [N_OUT*32-1:0]     out_data_i,
  input  logic [N_OUT-1:0]        out_en_i,
  output logic [N_OUT-1:0]        out_rdy_o
);
  localparam int unsigned   ENT_W  = $bits(in_ent_t);
  localparam logic [CHAN_W:0] IN_LIM = (CHAN_W+1)'(N_IN);

  // inbound path
  in_ent_t            wr_ent, head;
  logic [ENT_W-1:0]   head_raw;
  logic               in_push, in_pop, in_full, in_empty;

  assign in_push     = dma_wen_i && ({1'b0, dma_chan_i} < IN_LIM);
  assign wr_ent.eos  = dma_ctrl_i;
  assign wr_ent.chan = dma_chan_i;
  assign wr_ent.data = dma_wdata_i;
  assign head        = in_ent_t'(head_raw);

  dsb_fifo #(.W(ENT_W), .DEPTH(IN_DEPTH)) u_in_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (in_push),
    .wdata_i (wr_ent),
    .pop_i   (in_pop),
    .rdata_o (head_raw),
    .full_o  (in_full),
    .empty_o (in_empty)
  );

  dsb_in_steer #(.N_IN(N_IN)) u_in_steer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .head_i     (head),
    .head_vld_i (!in_empty),
    .in_rdy_i   (in_rdy_i),
    .pop_o      (in_pop),
    .in_data_o  (in_data_o),
    .in_en_o    (in_en_o),
    .in_eos_o   (in_eos_o)
  );

  // outbound path
  logic  out_push, out_full, out_empty;
  word_t out_wdata;

  dsb_out_sel #(.N_OUT(N_OUT)) u_out_sel (
    .dma_chan_i  (dma_chan_i),
    .dma_ren_i   (dma_ren_i),
    .fifo_full_i (out_full),
    .out_data_i  (out_data_i),
    .out_en_i    (out_en_i),
    .out_rdy_o   (out_rdy_o),
    .push_o      (out_push),
    .push_data_o (out_wdata)
  );

  assign core_wen_o = !out_empty && !core_full_i;

  dsb_fifo #(.W(WORD_W), .DEPTH(OUT_DEPTH)) u_out_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (out_push),
    .wdata_i (out_wdata),
    .pop_i   (core_wen_o),
    .rdata_o (core_wdata_o),
    .full_o  (out_full),
    .empty_o (out_empty)
  );

  logic unused_full;
  assign unused_full = in_full;
endmodule

// File: rtl/dsb_chk.sv
module dsb_chk #(
  parameter int unsigned N_IN  = 2,
  parameter int unsigned N_OUT = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                dma_ren_i,
  input logic                core_full_i,
  input logic                core_wen_o,
  input logic [N_IN*32-1:0]  in_data_o,
  input logic [N_IN-1:0]     in_en_o,
  input logic [N_IN-1:0]     in_rdy_i,
  input logic [N_IN-1:0]     in_eos_o,
  input logic [N_OUT-1:0]    out_rdy_o
);
  // R7
  core_full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_full_i |-> !core_wen_o);

  // R6
  out_rdy_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_rdy_o));

  // R6
  out_rdy_ren_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|out_rdy_o) |-> dma_ren_i);

  // R1
  in_en_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_en_o));

  // R3
  in_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(in_en_o & ~in_rdy_i)) |=> ($stable(in_en_o) && $stable(in_data_o)));

  // R5
  eos_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(in_eos_o) & ~in_eos_o) == '0));
endmodule

bind dma_stream_bridge dsb_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_dsb_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dma_ren_i   (dma_ren_i),
  .core_full_i (core_full_i),
  .core_wen_o  (core_wen_o),
  .in_data_o   (in_data_o),
  .in_en_o     (in_en_o),
  .in_rdy_i    (in_rdy_i),
  .in_eos_o    (in_eos_o),
  .out_rdy_o   (out_rdy_o)
);

// File: tb/tb_dma_stream_bridge.sv
`timescale 1ns/1ps
module tb_dma_stream_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wen = 1'b0, ctrl = 1'b0, ren = 1'b0, core_full = 1'b0;
  logic [3:0]  chan = '0;
  logic [31:0] wdata = '0;
  logic        core_wen;
  logic [31:0] core_wdata;
  logic [63:0] in_data;
  logic [1:0]  in_en, in_rdy, in_eos;
  logic [63:0] out_data = '0;
  logic [1:0]  out_en = '0;
  logic [1:0]  out_rdy;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] rx0[$], rx1[$], core_q[$];
  int   rdy_mode[2];           // 0 low, 1 high, 2 alternate
  int   o1_idx = 0, o1_lim = 0, out0_cnt = 0;
  logic take1 = 1'b0, o0_on = 1'b0;

  always #5 clk = ~clk;

  dma_stream_bridge dut (
    .clk_i(clk), .rst_ni(rst_n), .dma_wen_i(wen), .dma_ctrl_i(ctrl),
    .dma_chan_i(chan), .dma_wdata_i(wdata), .dma_ren_i(ren),
    .core_full_i(core_full), .core_wen_o(core_wen), .core_wdata_o(core_wdata),
    .in_data_o(in_data), .in_en_o(in_en), .in_rdy_i(in_rdy), .in_eos_o(in_eos),
    .out_data_i(out_data), .out_en_i(out_en), .out_rdy_o(out_rdy)
  );

  // monitor: state is stable from posedge+1 to the next posedge
  always @(negedge clk) if (rst_n) begin
    if (in_en[0] && in_rdy[0]) rx0.push_back(in_data[31:0]);
    if (in_en[1] && in_rdy[1]) rx1.push_back(in_data[63:32]);
    if (core_wen) core_q.push_back(core_wdata);
    if (out_en[0] && out_rdy[0]) out0_cnt++;
    take1 = out_en[1] && out_rdy[1];
  end

  // stream-side drivers
  initial begin rdy_mode[0] = 1; rdy_mode[1] = 1; in_rdy = 2'b00; end
  always @(posedge clk) begin
    #1;
    for (int k = 0; k < 2; k++) begin
      if (rdy_mode[k] == 0)      in_rdy[k] = 1'b0;
      else if (rdy_mode[k] == 1) in_rdy[k] = 1'b1;
      else                       in_rdy[k] = ~in_rdy[k];
    end
    if (take1) o1_idx++;
    out_data[63:32] = 32'hB000_0000 + o1_idx;
    out_en[1]       = (o1_idx < o1_lim);
    out_data[31:0]  = 32'hDEAD_0000;
    out_en[0]       = o0_on;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic burst(input logic [3:0] c, input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      wen = 1'b1; ctrl = 1'b0; chan = c; wdata = base + i;
    end
    @(posedge clk); #1;
    wen = 1'b0;
  endtask

  task automatic close_req(input logic [3:0] c);
    @(posedge clk); #1;
    wen = 1'b1; ctrl = 1'b1; chan = c; wdata = 32'hEEEE_EEEE;
    @(posedge clk); #1;
    wen = 1'b0; ctrl = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8 in_en", {30'd0, in_en}, 32'd0);
    chk("R8 in_eos", {30'd0, in_eos}, 32'd0);
    chk("R8 core_wen", {31'd0, core_wen}, 32'd0);
    chk("R8 out_rdy", {30'd0, out_rdy}, 32'd0);
  endtask

  task automatic t_decode();
    rx0.delete(); rx1.delete();
    burst(4'd0, 32'h100, 5);
    burst(4'd1, 32'h200, 3);
    burst(4'd5, 32'h500, 2);
    cycles(30);
    chk("R1 stream0 count", rx0.size(), 5);
    chk("R1 stream1 count", rx1.size(), 3);
    for (int i = 0; i < rx0.size(); i++) chk("R2 stream0 order", rx0[i], 32'h100 + i);
    for (int i = 0; i < rx1.size(); i++) chk("R1 stream1 data", rx1[i], 32'h200 + i);
  endtask

  task automatic t_alternate();
    rx0.delete();
    rdy_mode[0] = 2;
    burst(4'd0, 32'h300, 10);
    cycles(40);
    chk("R2 alt count", rx0.size(), 10);
    for (int i = 0; i < rx0.size(); i++) chk("R2 alt order", rx0[i], 32'h300 + i);
    rx0.delete();
    rdy_mode[0] = 0;
    cycles(2);
    burst(4'd0, 32'h3AA, 1);
    cycles(5);
    chk("R3 held en", {31'd0, in_en[0]}, 32'd1);
    chk("R3 held data", in_data[31:0], 32'h3AA);
    chk("R3 no move while low", rx0.size(), 0);
    rdy_mode[0] = 1;
    cycles(5);
    chk("R3 moved when high", rx0.size(), 1);
  endtask

  task automatic t_full();
    rx1.delete();
    rdy_mode[1] = 0;
    cycles(2);
    burst(4'd1, 32'h400, 20);
    cycles(3);
    rdy_mode[1] = 1;
    cycles(40);
    chk("R4 kept count", rx1.size(), 16);
    for (int i = 0; i < rx1.size(); i++) chk("R4 kept data", rx1[i], 32'h400 + i);
  endtask

  task automatic t_eos();
    rx0.delete();
    rdy_mode[0] = 0;
    cycles(2);
    burst(4'd0, 32'h600, 3);
    close_req(4'd0);
    cycles(6);
    chk("R5 eos waits for drain", {30'd0, in_eos}, 32'd0);
    rdy_mode[0] = 1;
    cycles(20);
    chk("R5 eos set on stream0", {30'd0, in_eos}, 32'd1);
    chk("R5 data before eos", rx0.size(), 3);
    chk("R5 no enable after close", {30'd0, in_en}, 32'd0);
    cycles(10);
    chk("R5 eos sticky", {30'd0, in_eos}, 32'd1);
  endtask

  task automatic t_out();
    core_q.delete();
    out0_cnt = 0;
    core_full = 1'b1;
    o0_on = 1'b1;
    cycles(2);
    chk("R6 no ready without read", {30'd0, out_rdy}, 32'd0);
    @(posedge clk); #1;
    ren = 1'b1; chan = 4'd1; o1_lim = 24;
    cycles(30);
    chk("R9 full drops ready", {30'd0, out_rdy}, 32'd0);
    chk("R7 no write while full", core_q.size(), 0);
    chk("R6 other stream idle", out0_cnt, 0);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      core_full = i[0];
    end
    @(posedge clk); #1;
    core_full = 1'b0;
    cycles(40);
    chk("R7 all words out", core_q.size(), 24);
    for (int i = 0; i < core_q.size(); i++) chk("R7 out order", core_q[i], 32'hB000_0000 + i);
    chk("R6 unselected stream", out0_cnt, 0);
    @(posedge clk); #1;
    ren = 1'b0; o0_on = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_decode();
    t_alternate();
    t_full();
    t_eos();
    t_out();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule